// File: doc/BRIEF.md
# SD/eMMC Host Interrupt Status and Enable Unit

This unit gathers the event flags of an SD/eMMC host controller into one 16-bit sticky status word and masks that word with a 14-bit enable register to drive a single interrupt line. Event sources elsewhere in the controller pulse one input bit per event for one cycle. Each pulse latches the matching status bit. The bit then stays set until software acknowledges it.

Software sees two word registers on a simple single-cycle port, one for status and one for enable. Reads are combinational from the current register state. A write takes effect at the next clock edge. A status write acknowledges events: each one in the write data clears the matching bit, and each zero leaves its bit unchanged. The status word also carries a live busy indication from the command engine in bit 31. That bit is read-only.

Top module: `sd_irq_unit`

## Requirements
- R1: After reset, all status bits and all enable bits are 0 and `irq` is low.
- R2: A one on `evt_pulse[i]` sets status bit i at the next clock edge, and the bit then stays set. The status layout is: bits 7:0 receive CRC error (one bit per data line), 8 transmit error, 9 descriptor error, 10 response error, 11 response timeout, 12 descriptor timeout, 13 end of chain, 14 response status, 15 card interrupt.
- R3: A write to the status offset (0x48) clears every status bit i whose write-data bit i is 1. It leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event and a clear hit the same status bit in the same cycle, the event wins and the bit is 1 after the edge.
- R5: A write to the enable offset (0x4C) loads write-data bits 13:0 into the enable register. Reading the enable offset returns those 14 bits, with bits 31:14 read as 0.
- R6: `irq` is high exactly when some status bit i with i in 13:0 has enable bit i set. Status bits 14 and 15 never raise `irq`.
- R7: Reading the status offset returns `ctrl_busy` in bit 31, the status in bits 15:0 and 0 in bits 30:16. Write-data bits 31:16 have no effect on the status.
- R8: Reads of any other offset return 0, and writes to any other offset change neither status nor enable.
- R9: A status write leaves the enable register unchanged, and an enable write leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_pulse | input | 16 | Event pulses, one per status bit |
| ctrl_busy | input | 1 | Live busy flag, reported in status bit 31 |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks every status bit through the full sequence of set, enabled interrupt, ignored zero-write and acknowledge. A unit that forgets a bit, or lets bit 14 or 15 interrupt, fails at that bit. For each bit it also applies an event together with an all-ones acknowledge. A design where the clear wins would lose the event that just arrived. It writes ones to bit 31 and the upper bits, to the wrong register and to an unmapped offset, and checks that nothing moves. A long random mix of events, acknowledges, enable writes and busy changes is checked every cycle against an arithmetic model of the registers. This catches ordering mistakes between set and clear across bits.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
    localparam int EVT_N   = 16;
    localparam int ENA_N   = 14;
    localparam int BUSY_IX = 31;

    typedef enum logic [3:0] {
        EV_TX_ERR     = 4'd8,
        EV_DESC_ERR   = 4'd9,
        EV_RESP_ERR   = 4'd10,
        EV_RESP_TMO   = 4'd11,
        EV_DESC_TMO   = 4'd12,
        EV_CHAIN_DONE = 4'd13,
        EV_RESP_STAT  = 4'd14,
        EV_CARD_INT   = 4'd15
    } evt_index_e;
endpackage

// File: rtl/sd_irq_status_cell.sv
module sd_irq_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic bit_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign bit_o = q;

    // R2 / R4: an event always leaves the bit set, even under a clear
    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> bit_o);
    // R3: an acknowledge without an event empties the bit
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !bit_o);
    // R2: sticky when nothing touches it
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(bit_o));
endmodule

// File: rtl/sd_irq_status_bank.sv
module sd_irq_status_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        sd_irq_status_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_i[g]),
            .clr_i (clr_i[g]),
            .bit_o (stat_o[g])
        );
    end
endmodule

// File: rtl/sd_irq_enable_reg.sv
module sd_irq_enable_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= data_i;
    end

    assign en_o = en_q;

    // R5: a write loads the mask
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(data_i)));
    // R9: no write, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/sd_irq_unit.sv
module sd_irq_unit
    import sd_irq_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 32,
    parameter logic [7:0]  STATUS_OFS = 8'h48,
    parameter logic [7:0]  ENABLE_OFS = 8'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic              ctrl_busy,
    output logic              irq
);
    localparam int PAD_N = EVT_N - ENA_N;

    logic              hit_stat, hit_ena;
    logic [EVT_N-1:0]  ack_vec, stat;
    logic [ENA_N-1:0]  ena;
    logic              unused_wdata_hi;

    assign hit_stat        = (reg_addr == ADDR_W'(STATUS_OFS));
    assign hit_ena         = (reg_addr == ADDR_W'(ENABLE_OFS));
    assign ack_vec         = (reg_wr && hit_stat) ? reg_wdata[EVT_N-1:0] : '0;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EVT_N];

    sd_irq_status_bank #(.N(EVT_N)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .clr_i  (ack_vec),
        .stat_o (stat)
    );

    sd_irq_enable_reg #(.W(ENA_N)) u_ena (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr && hit_ena),
        .data_i (reg_wdata[ENA_N-1:0]),
        .en_o   (ena)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_stat) begin
            reg_rdata[EVT_N-1:0] = stat;
            reg_rdata[BUSY_IX]   = ctrl_busy;
        end else if (hit_ena) begin
            reg_rdata[ENA_N-1:0] = ena;
        end
    end

    assign irq = |(stat & {{PAD_N{1'b0}}, ena});

    // R6: a cleared mask silences the line
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ena == '0) |-> !irq);
    // R6: the line needs a pending low-order status bit
    a_r6_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat[ENA_N-1:0] != '0));
    // R8: unmapped offsets read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stat && !hit_ena) |-> (reg_rdata == '0));
    // R5: enable read never shows upper bits
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ena |-> (reg_rdata[DATA_W-1:ENA_N] == '0));
endmodule

// File: tb/sd_irq_unit_tb_top.sv
module sd_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h48;
    localparam logic [7:0] A_ENA  = 8'h4C;
    localparam logic [7:0] A_NONE = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = A_STAT;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_pulse = '0;
    logic        ctrl_busy = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_stat = '0;
    logic [13:0] m_ena  = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .ctrl_busy(ctrl_busy), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // one clocked operation; called at a negedge, returns at the next negedge
    task automatic op(input logic [15:0] e, input logic w, input logic [7:0] a, input logic [31:0] d);
        evt_pulse = e; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (w && a == A_STAT) m_stat = m_stat & ~d[15:0];
        m_stat = m_stat | e;
        if (w && a == A_ENA) m_ena = d[13:0];
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
    endtask

    task automatic check_all(input string req);
        reg_addr = A_STAT; #1;
        check(req, reg_rdata, {ctrl_busy, 15'd0, m_stat});
        reg_addr = A_ENA; #1;
        check(req, reg_rdata, {18'd0, m_ena});
        check(req, {31'd0, irq}, {31'd0, |(m_stat & {2'b00, m_ena})});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1");
        reg_addr = A_NONE; #1;
        check("R8", reg_rdata, 32'd0);

        // sweep every status bit
        for (int i = 0; i < 16; i++) begin
            op(16'(1 << i), 1'b0, A_STAT, 32'd0);
            check_all("R2");
            op(16'd0, 1'b0, A_STAT, 32'd0);
            check_all("R2");
            op(16'd0, 1'b1, A_ENA, 32'hFFFF_FFFF);
            check_all("R5");
            check("R6", {31'd0, irq}, {31'd0, (i < 14)});
            op(16'd0, 1'b1, A_STAT, ~(32'd1 << i));
            check_all("R3");
            op(16'd0, 1'b1, A_ENA, 32'd0);
            check_all("R9");
            check("R6", {31'd0, irq}, 32'd0);
            op(16'd0, 1'b1, A_STAT, 32'd1 << i);
            check_all("R3");
        end

        // event and acknowledge together
        for (int k = 0; k < 16; k++) begin
            op(16'hFFFF, 1'b0, A_STAT, 32'd0);
            op(16'(1 << k), 1'b1, A_STAT, 32'h0000_FFFF);
            check_all("R4");
            check("R4", {16'd0, m_stat}, 32'd1 << k);
            op(16'd0, 1'b1, A_STAT, 32'h0000_FFFF);
        end

        // walking enable with all status set
        op(16'hFFFF, 1'b0, A_STAT, 32'd0);
        for (int j = 0; j < 14; j++) begin
            op(16'd0, 1'b1, A_ENA, 32'd1 << j);
            check_all("R6");
        end

        // busy bit and upper write bits
        ctrl_busy = 1'b1; #1;
        check_all("R7");
        op(16'd0, 1'b1, A_STAT, 32'hFFFF_0000);
        check_all("R7");
        ctrl_busy = 1'b0; #1;
        check_all("R7");

        // unmapped offset
        op(16'd0, 1'b1, A_NONE, 32'hFFFF_FFFF);
        check_all("R8");
        reg_addr = A_NONE; #1;
        check("R8", reg_rdata, 32'd0);
        op(16'd0, 1'b1, A_STAT, 32'hFFFF_FFFF);
        check_all("R9");

        // random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [15:0] e;
            logic [7:0]  a;
            rng = next_rng(rng);
            e = rng[15:0] & rng[31:16] & next_rng(rng)[15:0];
            a = (rng[3:2] == 2'd0) ? A_ENA : (rng[3:2] == 2'd1) ? A_NONE : A_STAT;
            ctrl_busy = rng[9];
            op(e, rng[5], a, next_rng(next_rng(rng)));
            check_all("R2 R3 R4 R6 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule